// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by reading descriptors from a translation table held in memory. A request is a virtual address with a valid strobe. The walker samples the table base input and the translation-enable input when it accepts the request. It reads one or two 32-bit descriptors through a single read port that uses a valid/ready handshake. It then returns the physical address with a fault flag and a flag for an illegal descriptor combination.

At the first level, a descriptor either maps a 1 MB section directly, or points at a coarse second-level table, or is unusable. A coarse-table entry then maps a 64 KB, 4 KB or 1 KB page. Fine second-level tables are not walked and are reported as faults. The same translation serves every access kind: instruction fetches of either instruction width, and data reads and writes of 8, 16 or 32 bits. The caller uses the same request for all of them.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `rsp_valid` and `mem_rd_valid` are both 0.
- R2: A request accepted while `mmu_en` is 0 makes no memory read. `rsp_paddr` equals `req_vaddr`, and `rsp_valid` is 1 in the cycle after the accepting clock edge.
- R3: The first descriptor is read from `ttb[31:14]` (bits 13:0 cleared) ORed with `req_vaddr[31:20]` shifted left by 2.
- R4: The first-level type is bits 1:0 of the descriptor: 0 is unmapped, 1 is a coarse table, 2 is a section and 3 is a fine table. Types 0 and 3 end the walk after one read with `rsp_fault`=1 and `rsp_paddr` equal to the virtual address.
- R5: For a section, `rsp_paddr` is descriptor bits 31:20 joined with virtual bits 19:0, with no fault.
- R6: For a coarse table, the second descriptor is read from descriptor bits 31:10 (bits 9:0 cleared) ORed with virtual bits 19:12 shifted left by 2.
- R7: The second-level type is bits 1:0: 0 is unmapped and faults with `rsp_paddr` equal to the virtual address. 1 is a 64 KB page (descriptor 31:16, virtual 15:0) and 2 is a 4 KB page (descriptor 31:12, virtual 11:0).
- R8: Type 3 at the second level is a 1 KB page (descriptor 31:10, virtual 9:0). Because it can only be reached through a coarse table, it is flagged with `rsp_tiny`=1 and `rsp_fault`=0.
- R9: `rsp_valid` is high for exactly one cycle per accepted request. `rsp_fault` and `rsp_tiny` are 0 whenever `rsp_valid` is 0.
- R10: A `req_valid` seen while a walk is in progress is dropped without effect. Changes to `ttb` and `mmu_en` after acceptance do not alter the walk under way.
- R11: Once `mem_rd_valid` is raised, it and `mem_rd_addr` hold steady until a cycle with `mem_rd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_en | input | 1 | Translation enable, sampled on acceptance |
| ttb | input | 32 | Translation table base, sampled on acceptance |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_vaddr | input | 32 | Virtual address |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_ready | input | 1 | Read completes this cycle |
| mem_rd_data | input | 32 | Descriptor returned with ready |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Translation fault |
| rsp_tiny | output | 1 | 1 KB page reached through a coarse table |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, a 16 KB-aligned first-level table, 1 MB sections, coarse tables of 256 entries, and 64 KB, 4 KB and 1 KB pages. These values give every descriptor type at both levels, as well as the top first-level index (virtual 0xFFF00000 and up). Alternate vectors stall the read port for two cycles, which exercises address hold and the dropping of requests that arrive mid-walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_L1   = 2'd1,
      ST_L2   = 2'd2,
      ST_DONE = 2'd3
   } ptw_state_e;

   typedef enum logic [1:0] {
      L1_UNMAPPED = 2'd0,
      L1_COARSE   = 2'd1,
      L1_SECTION  = 2'd2,
      L1_FINE     = 2'd3
   } l1_kind_e;

   typedef enum logic [1:0] {
      L2_UNMAPPED = 2'd0,
      L2_LARGE    = 2'd1,
      L2_SMALL    = 2'd2,
      L2_TINY     = 2'd3
   } l2_kind_e;
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
   import ptw_pkg::*;
#(
   parameter int AW         = 32,
   parameter int SEC_LSB    = 20,
   parameter int CT_LSB     = 10,
   parameter int L2_IDX_LSB = 12
) (
   input  logic [AW-1:0] desc,
   input  logic [AW-1:0] vaddr,
   output l1_kind_e      kind,
   output logic [AW-1:0] sec_paddr,
   output logic [AW-1:0] l2_addr
);
   localparam logic [AW-1:0] SEC_MASK  = {AW{1'b1}} << SEC_LSB;
   localparam logic [AW-1:0] CT_MASK   = {AW{1'b1}} << CT_LSB;
   localparam logic [AW-1:0] IDX2_MASK = ~({AW{1'b1}} << (SEC_LSB - L2_IDX_LSB));

   always_comb begin
      kind      = l1_kind_e'(desc[1:0]);
      sec_paddr = (desc & SEC_MASK) | (vaddr & ~SEC_MASK);
      l2_addr   = (desc & CT_MASK) | (((vaddr >> L2_IDX_LSB) & IDX2_MASK) << 2);
   end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
   import ptw_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LARGE_LSB = 16,
   parameter int SMALL_LSB = 12,
   parameter int TINY_LSB  = 10
) (
   input  logic [AW-1:0] desc,
   input  logic [AW-1:0] vaddr,
   output logic [AW-1:0] paddr,
   output logic          fault,
   output logic          tiny
);
   localparam logic [AW-1:0] LARGE_MASK = {AW{1'b1}} << LARGE_LSB;
   localparam logic [AW-1:0] SMALL_MASK = {AW{1'b1}} << SMALL_LSB;
   localparam logic [AW-1:0] TINY_MASK  = {AW{1'b1}} << TINY_LSB;

   logic [AW-1:0] mask;

   always_comb begin
      fault = 1'b0;
      tiny  = 1'b0;
      mask  = '0;
      unique case (l2_kind_e'(desc[1:0]))
         L2_LARGE:    mask = LARGE_MASK;
         L2_SMALL:    mask = SMALL_MASK;
         L2_TINY: begin
            mask = TINY_MASK;
            tiny = 1'b1;
         end
         default:     fault = 1'b1;
      endcase
      paddr = fault ? vaddr : ((desc & mask) | (vaddr & ~mask));
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int AW         = 32,
   parameter int TTB_LSB    = 14,
   parameter int SEC_LSB    = 20,
   parameter int CT_LSB     = 10,
   parameter int L2_IDX_LSB = 12,
   parameter int LARGE_LSB  = 16,
   parameter int SMALL_LSB  = 12,
   parameter int TINY_LSB   = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mmu_en,
   input  logic [31:0]   ttb,
   input  logic          req_valid,
   input  logic [31:0]   req_vaddr,
   output logic          mem_rd_valid,
   output logic [31:0]   mem_rd_addr,
   input  logic          mem_rd_ready,
   input  logic [31:0]   mem_rd_data,
   output logic          rsp_valid,
   output logic [31:0]   rsp_paddr,
   output logic          rsp_fault,
   output logic          rsp_tiny
);
   localparam logic [AW-1:0] TTB_MASK = {AW{1'b1}} << TTB_LSB;

   // elaboration-time parameter checks
   if (AW != 32) begin : g_bad_aw
      $error("ptw_walker: port widths assume AW of 32");
   end
   if (TTB_LSB != AW - SEC_LSB + 2) begin : g_bad_ttb
      $error("ptw_walker: first-level table size does not match section size");
   end
   if (CT_LSB != SEC_LSB - L2_IDX_LSB + 2) begin : g_bad_ct
      $error("ptw_walker: coarse table size does not match its index field");
   end
   if (!(LARGE_LSB > SMALL_LSB && SMALL_LSB > TINY_LSB && TINY_LSB >= 2)) begin : g_bad_pg
      $error("ptw_walker: page sizes must be strictly ordered");
   end
   if (L2_IDX_LSB != SMALL_LSB) begin : g_bad_idx
      $error("ptw_walker: second-level index must start at the small-page boundary");
   end

   ptw_state_e    state_q;
   logic [AW-1:0] va_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] paddr_q;
   logic          fault_q;
   logic          tiny_q;

   l1_kind_e      l1_kind;
   logic [AW-1:0] l1_sec_pa;
   logic [AW-1:0] l1_next;
   logic [AW-1:0] l2_pa;
   logic          l2_fault;
   logic          l2_tiny;
   logic [AW-1:0] first_addr;

   ptw_l1_dec #(
      .AW(AW), .SEC_LSB(SEC_LSB), .CT_LSB(CT_LSB), .L2_IDX_LSB(L2_IDX_LSB)
   ) i_l1 (
      .desc(mem_rd_data), .vaddr(va_q), .kind(l1_kind),
      .sec_paddr(l1_sec_pa), .l2_addr(l1_next)
   );

   ptw_l2_dec #(
      .AW(AW), .LARGE_LSB(LARGE_LSB), .SMALL_LSB(SMALL_LSB), .TINY_LSB(TINY_LSB)
   ) i_l2 (
      .desc(mem_rd_data), .vaddr(va_q), .paddr(l2_pa),
      .fault(l2_fault), .tiny(l2_tiny)
   );

   assign first_addr = (ttb & TTB_MASK) | ((req_vaddr >> SEC_LSB) << 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         addr_q  <= '0;
         paddr_q <= '0;
         fault_q <= 1'b0;
         tiny_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               fault_q <= 1'b0;
               tiny_q  <= 1'b0;
               if (req_valid) begin
                  va_q <= req_vaddr;
                  if (mmu_en) begin
                     addr_q  <= first_addr;
                     state_q <= ST_L1;
                  end else begin
                     paddr_q <= req_vaddr;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_L1: begin
               if (mem_rd_ready) begin
                  unique case (l1_kind)
                     L1_SECTION: begin
                        paddr_q <= l1_sec_pa;
                        state_q <= ST_DONE;
                     end
                     L1_COARSE: begin
                        addr_q  <= l1_next;
                        state_q <= ST_L2;
                     end
                     default: begin
                        paddr_q <= va_q;
                        fault_q <= 1'b1;
                        state_q <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_L2: begin
               if (mem_rd_ready) begin
                  paddr_q <= l2_pa;
                  fault_q <= l2_fault;
                  tiny_q  <= l2_tiny;
                  state_q <= ST_DONE;
               end
            end
            default: begin
               fault_q <= 1'b0;
               tiny_q  <= 1'b0;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign mem_rd_valid = (state_q == ST_L1) || (state_q == ST_L2);
   assign mem_rd_addr  = addr_q;
   assign rsp_valid    = (state_q == ST_DONE);
   assign rsp_paddr    = paddr_q;
   assign rsp_fault    = rsp_valid && fault_q;
   assign rsp_tiny     = rsp_valid && tiny_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mem_rd_valid,
   input logic [31:0] mem_rd_addr,
   input logic        mem_rd_ready,
   input logic        rsp_valid,
   input logic        rsp_fault,
   input logic        rsp_tiny
);
   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R9
   flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_tiny) |-> rsp_valid);

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R9
   rsp_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_rd_valid);

   // R8
   tiny_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_tiny |-> !rsp_fault);

   // R10
   idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !mem_rd_valid);
endmodule

bind ptw_walker ptw_walker_chk i_ptw_walker_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd_valid(mem_rd_valid),
   .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
   .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_tiny(rsp_tiny)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mmu_en = 1'b0;
   logic [31:0] ttb = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ready;
   logic [31:0] mem_rd_data;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        rsp_tiny;

   int n_run = 0;
   int n_fail = 0;
   int lat_cfg = 0;
   int lat_cnt = 0;
   int rd_n = 0;
   logic [31:0] rd_log [4];
   int hold_err = 0;
   logic        prev_v = 1'b0;
   logic        prev_r = 1'b0;
   logic [31:0] prev_a = '0;

   always #2.5 clk = ~clk;

   ptw_walker i_ptw_walker (
      .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .ttb(ttb),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_tiny(rsp_tiny)
   );

   function automatic logic [31:0] mem_fn(logic [31:0] a);
      case (a)
         32'h0000_4004: return 32'h8010_0C02;  // section
         32'h0000_4008: return 32'h0000_8001;  // coarse table at 0x8000
         32'h0000_400C: return 32'h0000_9003;  // fine table
         32'h0000_7FFC: return 32'h0010_0002;  // section, top index
         32'h0000_8004: return 32'h1234_5671;  // large page
         32'h0000_8008: return 32'hABCD_E012;  // small page
         32'h0000_800C: return 32'h5555_5C03;  // tiny page
         default:       return 32'h0000_0000;  // unmapped
      endcase
   endfunction

   always_comb begin
      mem_rd_ready = mem_rd_valid && (lat_cnt >= lat_cfg);
      mem_rd_data  = mem_rd_ready ? mem_fn(mem_rd_addr) : 32'h0;
   end

   always @(posedge clk) begin
      if (mem_rd_valid && mem_rd_ready) begin
         if (rd_n < 4) rd_log[rd_n] <= mem_rd_addr;
         rd_n    <= rd_n + 1;
         lat_cnt <= 0;
      end else if (mem_rd_valid) begin
         lat_cnt <= lat_cnt + 1;
      end
      if (rst_n && prev_v && !prev_r && (!mem_rd_valid || mem_rd_addr != prev_a))
         hold_err <= hold_err + 1;
      prev_v <= mem_rd_valid;
      prev_r <= mem_rd_ready;
      prev_a <= mem_rd_addr;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        mmu;
      logic [31:0] va;
      logic [31:0] pa;
      logic        flt;
      logic        tny;
      logic [1:0]  nrd;
      logic [31:0] l1a;
      logic [31:0] l2a;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0, 2'd0, 32'h0,      32'h0},      // R2
      '{1'b1, 32'h0012_3456, 32'h8012_3456, 1'b0, 1'b0, 2'd1, 32'h4004, 32'h0},      // R5
      '{1'b1, 32'h0020_1234, 32'h1234_1234, 1'b0, 1'b0, 2'd2, 32'h4008, 32'h8004},   // R7 large
      '{1'b1, 32'h0020_2ABC, 32'hABCD_EABC, 1'b0, 1'b0, 2'd2, 32'h4008, 32'h8008},   // R7 small
      '{1'b1, 32'h0020_3155, 32'h5555_5D55, 1'b0, 1'b1, 2'd2, 32'h4008, 32'h800C},   // R8
      '{1'b1, 32'h0020_4000, 32'h0020_4000, 1'b1, 1'b0, 2'd2, 32'h4008, 32'h8010},   // R7 fault
      '{1'b1, 32'h0030_0010, 32'h0030_0010, 1'b1, 1'b0, 2'd1, 32'h400C, 32'h0},      // R4 fine
      '{1'b1, 32'h0040_0010, 32'h0040_0010, 1'b1, 1'b0, 2'd1, 32'h4010, 32'h0},      // R4 unmapped
      '{1'b1, 32'hFFF8_0001, 32'h0018_0001, 1'b0, 1'b0, 2'd1, 32'h7FFC, 32'h0},      // R3 top index
      '{1'b0, 32'h0012_3456, 32'h0012_3456, 1'b0, 1'b0, 2'd0, 32'h0,      32'h0}       // R2
   };

   task automatic issue(logic m, logic [31:0] va);
      @(negedge clk);
      mmu_en    = m;
      req_vaddr = va;
      req_valid = 1'b1;
      rd_n      = 0;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(output int waited);
      waited = 1;
      while (!rsp_valid && waited < 1000) begin
         @(negedge clk);
         waited++;
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end

   initial begin
      int w;
      ttb = 32'h0000_7ABC;  // low bits must be ignored, base 0x4000
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
      chk("R1 mem_rd_valid in reset", {31'b0, mem_rd_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
      chk("R1 mem_rd_valid after reset", {31'b0, mem_rd_valid}, 32'd0);

      for (int i = 0; i < 10; i++) begin
         lat_cfg = (i % 2) ? 2 : 0;
         issue(VECS[i].mmu, VECS[i].va);
         wait_rsp(w);
         chk($sformatf("R5/R7 paddr v%0d", i), rsp_paddr, VECS[i].pa);
         chk($sformatf("R4/R7 fault v%0d", i), {31'b0, rsp_fault}, {31'b0, VECS[i].flt});
         chk($sformatf("R8 tiny v%0d", i), {31'b0, rsp_tiny}, {31'b0, VECS[i].tny});
         chk($sformatf("R4/R6 reads v%0d", i), rd_n, {30'b0, VECS[i].nrd});
         if (VECS[i].nrd == 2'd0)
            chk($sformatf("R2 latency v%0d", i), w, 32'd1);
         if (VECS[i].nrd >= 2'd1)
            chk($sformatf("R3 first address v%0d", i), rd_log[0], VECS[i].l1a);
         if (VECS[i].nrd == 2'd2)
            chk($sformatf("R6 second address v%0d", i), rd_log[1], VECS[i].l2a);
         @(negedge clk);
         chk($sformatf("R9 single pulse v%0d", i), {31'b0, rsp_valid}, 32'd0);
      end

      // R10: request during a walk is dropped; ttb/mmu_en changes do not matter
      lat_cfg = 2;
      issue(1'b1, 32'h0020_2ABC);
      ttb       = 32'h00FF_0000;
      mmu_en    = 1'b0;
      req_vaddr = 32'h0012_3456;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_rsp(w);
      chk("R10 paddr of first request", rsp_paddr, 32'hABCD_EABC);
      chk("R10 first address uses sampled ttb", rd_log[0], 32'h0000_4008);
      chk("R10 two reads", rd_n, 32'd2);
      repeat (4) begin
         @(negedge clk);
         chk("R10 no response for dropped request", {31'b0, rsp_valid}, 32'd0);
      end

      chk("R11 read address held while stalled", hold_err, 32'd0);
      finish_run();
   end
endmodule